// File: doc/BRIEF.md
# Home-Node Directory Coherence Controller

This block is the home node of a distributed shared-memory system with a small, fixed number of processors. It keeps two things for every memory block it owns. The first is the block's data. The second is a directory entry: a two-bit state (Uncached, Shared or Exclusive) and one sharer bit per processor. Miss and write-back messages from the processors' caches arrive on a valid/ready request port. Each message carries a kind, a processor number, a block address and, for write-backs, the data.

For each request the controller updates the directory entry and may write the memory. It issues the point-to-point messages that keep the caches coherent: invalidates to sharers, fetch or fetch-and-invalidate to an owner, and finally a data reply to the requester. All of these leave through one valid/ready message port. Invalidates go out one at a time from a small sequencer. A fetch suspends the controller until the owner's data comes back on the fetch-response input.

The controller handles one request at a time. This also covers the rule that no new request for the same block is taken while a fetch is outstanding. The fetch-response input is sampled only while a fetch is outstanding.

Top module: `dir_home_ctrl`

## Requirements
- R1: After reset every directory entry is Uncached with no sharers and every data word is zero. req_ready is 1 and out_valid is 0.
- R2: A read miss (req_kind 0) to an Uncached block replies at once with the memory data. The block becomes Shared with the requester as its only sharer.
- R3: A read miss to a Shared block adds the requester to the sharers and replies with the memory data.
- R4: A write miss (req_kind 1) to a Shared block sends an invalidate (out_kind 1) to every sharer other than the requester. The invalidates go out in ascending processor index, one per message handshake. Then the controller replies, and the block becomes Exclusive with the requester as owner. No invalidate is sent when the requester is the only sharer.
- R5: A write miss to an Uncached block replies with the memory data and makes the block Exclusive, owned by the requester.
- R6: A read miss to an Exclusive block sends a fetch (out_kind 2) to the owner and waits for fbk_valid. It then writes fbk_data to memory and replies with that data. The block becomes Shared, with the old owner and the requester as sharers.
- R7: A write miss to an Exclusive block sends a fetch-and-invalidate (out_kind 3) to the owner and writes the returned data to memory. It replies with that data, and the block stays Exclusive with the requester as the new owner.
- R8: A write-back (req_kind 2) from the owner of an Exclusive block writes req_data to memory and makes the block Uncached with no sharers, and sends no message. Any other write-back is ignored: no message is sent, and neither memory nor directory changes.
- R9: While out_valid is 1 and out_ready is 0, the outgoing message stays valid and unchanged.
- R10: After a read or write miss is accepted, req_ready stays 0 until the data reply (out_kind 4, sent to the requester) is handshaken. This includes the whole time a fetch response is outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request message present |
| req_ready | output | 1 | Controller can take a request |
| req_kind | input | 2 | 0 read miss, 1 write miss, 2 write-back |
| req_proc | input | PW | Requesting processor index |
| req_addr | input | AW | Block address |
| req_data | input | DW | Write-back data |
| fbk_valid | input | 1 | Fetch response from the owner present |
| fbk_data | input | DW | Block data returned by the owner |
| out_valid | output | 1 | Outgoing message present |
| out_ready | input | 1 | Interconnect takes the outgoing message |
| out_kind | output | 3 | 1 invalidate, 2 fetch, 3 fetch-and-invalidate, 4 data reply |
| out_dest | output | PW | Destination processor |
| out_addr | output | AW | Block address of the message |
| out_data | output | DW | Reply data (zero for other kinds) |

## Verification
The main function is driven through one block that runs through all three states. It sees reads that widen the sharer set, a write that must invalidate two sharers while skipping the requester, and fetches from an owner in both the read and write flavours. It also sees owner and stale write-backs. Each reply's data shows whether the memory was written by a fetch response or a write-back, or left alone by an ignored write-back. Whether a fetch appears or not shows the directory state left by the request before. The output port is stalled on a fixed rhythm. This checks invalidate order and message stability under backpressure, and a withheld fetch response checks that a pending request is refused.

// File: rtl/dir_home_pkg.sv
package dir_home_pkg;

  typedef enum logic [1:0] {
    DS_UNC = 2'd0,
    DS_SHR = 2'd1,
    DS_EXC = 2'd2
  } dstate_e;

  typedef enum logic [1:0] {
    RQ_READ  = 2'd0,
    RQ_WRITE = 2'd1,
    RQ_WBACK = 2'd2
  } rkind_e;

  typedef enum logic [2:0] {
    MO_NONE      = 3'd0,
    MO_INV       = 3'd1,
    MO_FETCH     = 3'd2,
    MO_FETCH_INV = 3'd3,
    MO_REPLY     = 3'd4
  } mkind_e;

  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_INV   = 3'd1,
    PH_FETCH = 3'd2,
    PH_WAIT  = 3'd3,
    PH_REPLY = 3'd4
  } phase_e;

endpackage

// File: rtl/dir_ram.sv
// Register array with one write port and one combinational read port.
// Cleared to zero by reset (small depth by design).
module dir_ram #(
  parameter int W     = 8,
  parameter int DEPTH = 16,
  parameter int AW    = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);

  logic [W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (we) begin
      mem_q[waddr] <= wdata;
    end
  end

  assign rdata = mem_q[raddr];

endmodule

// File: rtl/dir_inval_seq.sv
// Holds the set of sharers still to be invalidated and names the lowest one.
module dir_inval_seq #(
  parameter int NPROC = 4,
  parameter int PW    = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [NPROC-1:0] load_mask,
  input  logic             take,
  output logic [PW-1:0]    dest,
  output logic             last
);

  logic [NPROC-1:0] pend_q;

  function automatic logic [PW-1:0] lowest_idx(input logic [NPROC-1:0] m);
    logic [PW-1:0] r;
    r = '0;
    for (int i = NPROC - 1; i >= 0; i--) if (m[i]) r = PW'(i);
    return r;
  endfunction

  function automatic logic at_most_one(input logic [NPROC-1:0] m);
    return (m & (m - NPROC'(1))) == '0;
  endfunction

  assign dest = lowest_idx(pend_q);
  assign last = at_most_one(pend_q);

  always_ff @(posedge clk) begin
    if (!rst_n)      pend_q <= '0;
    else if (load)   pend_q <= load_mask;
    else if (take)   pend_q <= pend_q & ~(NPROC'(1) << dest);
  end

  // R4
  inv_shrink_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> ($countones(pend_q) == $countones($past(pend_q)) - 1)
             && ((pend_q & ~$past(pend_q)) == '0));

endmodule

// File: rtl/dir_home_ctrl.sv
module dir_home_ctrl
  import dir_home_pkg::*;
#(
  parameter int NPROC = 4,
  parameter int NBLK  = 16,
  parameter int DW    = 32,
  localparam int PW   = (NPROC > 1) ? $clog2(NPROC) : 1,
  localparam int AW   = (NBLK > 1) ? $clog2(NBLK) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [1:0]    req_kind,
  input  logic [PW-1:0] req_proc,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_data,
  input  logic          fbk_valid,
  input  logic [DW-1:0] fbk_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [2:0]    out_kind,
  output logic [PW-1:0] out_dest,
  output logic [AW-1:0] out_addr,
  output logic [DW-1:0] out_data
);

  localparam int EW = 2 + NPROC;

  function automatic logic [NPROC-1:0] proc_bit(input logic [PW-1:0] p);
    return NPROC'(1) << p;
  endfunction

  function automatic logic [PW-1:0] owner_of(input logic [NPROC-1:0] sh);
    logic [PW-1:0] r;
    r = '0;
    for (int i = 0; i < NPROC; i++) if (sh[i]) r = PW'(i);
    return r;
  endfunction

  function automatic logic [EW-1:0] pack_entry(input dstate_e s, input logic [NPROC-1:0] sh);
    return {s, sh};
  endfunction

  phase_e        ph_q, ph_d;
  rkind_e        kind_q;
  logic [PW-1:0] proc_q, owner_q;
  logic [AW-1:0] addr_q;

  // named events
  logic acc_fire, out_fire, inv_fire, fbk_take;

  logic [EW-1:0] dir_rdata, dir_wdata;
  logic          dir_we;
  logic [AW-1:0] wr_addr;
  logic [DW-1:0] mem_rdata, mem_wdata;
  logic          mem_we;

  dstate_e          cur_state;
  logic [NPROC-1:0] cur_sh, req_bit, others;
  rkind_e           req_k;

  logic          seq_load, seq_last;
  logic [PW-1:0] seq_dest;

  assign req_ready = (ph_q == PH_IDLE);
  assign acc_fire  = req_valid && req_ready;
  assign out_fire  = out_valid && out_ready;
  assign inv_fire  = out_fire && (ph_q == PH_INV);
  assign fbk_take  = fbk_valid && (ph_q == PH_WAIT);

  assign req_k     = rkind_e'(req_kind);
  assign cur_state = dstate_e'(dir_rdata[EW-1 -: 2]);
  assign cur_sh    = dir_rdata[NPROC-1:0];
  assign req_bit   = proc_bit(req_proc);
  assign others    = cur_sh & ~req_bit;
  assign wr_addr   = (ph_q == PH_IDLE) ? req_addr : addr_q;

  dir_ram #(.W(EW), .DEPTH(NBLK), .AW(AW)) u_dir (
    .clk(clk), .rst_n(rst_n), .we(dir_we), .waddr(wr_addr),
    .wdata(dir_wdata), .raddr(req_addr), .rdata(dir_rdata)
  );

  dir_ram #(.W(DW), .DEPTH(NBLK), .AW(AW)) u_mem (
    .clk(clk), .rst_n(rst_n), .we(mem_we), .waddr(wr_addr),
    .wdata(mem_wdata), .raddr(addr_q), .rdata(mem_rdata)
  );

  dir_inval_seq #(.NPROC(NPROC), .PW(PW)) u_seq (
    .clk(clk), .rst_n(rst_n), .load(seq_load), .load_mask(others),
    .take(inv_fire), .dest(seq_dest), .last(seq_last)
  );

  always_comb begin
    ph_d      = ph_q;
    dir_we    = 1'b0;
    dir_wdata = '0;
    mem_we    = 1'b0;
    mem_wdata = req_data;
    seq_load  = 1'b0;
    unique case (ph_q)
      PH_IDLE: if (acc_fire) begin
        unique case (req_k)
          RQ_READ: begin
            if (cur_state == DS_EXC) ph_d = PH_FETCH;
            else begin
              dir_we    = 1'b1;
              dir_wdata = pack_entry(DS_SHR, (cur_state == DS_SHR) ? (cur_sh | req_bit) : req_bit);
              ph_d      = PH_REPLY;
            end
          end
          RQ_WRITE: begin
            if (cur_state == DS_EXC) ph_d = PH_FETCH;
            else if (cur_state == DS_SHR && others != '0) begin
              seq_load = 1'b1;
              ph_d     = PH_INV;
            end else begin
              dir_we    = 1'b1;
              dir_wdata = pack_entry(DS_EXC, req_bit);
              ph_d      = PH_REPLY;
            end
          end
          default: begin
            if (cur_state == DS_EXC && cur_sh == req_bit) begin
              mem_we    = 1'b1;
              dir_we    = 1'b1;
              dir_wdata = pack_entry(DS_UNC, '0);
            end
          end
        endcase
      end
      PH_INV: if (inv_fire && seq_last) begin
        dir_we    = 1'b1;
        dir_wdata = pack_entry(DS_EXC, proc_bit(proc_q));
        ph_d      = PH_REPLY;
      end
      PH_FETCH: if (out_fire) ph_d = PH_WAIT;
      PH_WAIT: if (fbk_take) begin
        mem_we    = 1'b1;
        mem_wdata = fbk_data;
        dir_we    = 1'b1;
        dir_wdata = (kind_q == RQ_READ)
                  ? pack_entry(DS_SHR, proc_bit(owner_q) | proc_bit(proc_q))
                  : pack_entry(DS_EXC, proc_bit(proc_q));
        ph_d      = PH_REPLY;
      end
      PH_REPLY: if (out_fire) ph_d = PH_IDLE;
      default: ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph_q    <= PH_IDLE;
      kind_q  <= RQ_READ;
      proc_q  <= '0;
      owner_q <= '0;
      addr_q  <= '0;
    end else begin
      ph_q <= ph_d;
      if (acc_fire) begin
        kind_q  <= req_k;
        proc_q  <= req_proc;
        addr_q  <= req_addr;
        owner_q <= owner_of(cur_sh);
      end
    end
  end

  always_comb begin
    out_valid = 1'b0;
    out_kind  = MO_NONE;
    out_dest  = proc_q;
    out_data  = '0;
    unique case (ph_q)
      PH_INV: begin
        out_valid = 1'b1;
        out_kind  = MO_INV;
        out_dest  = seq_dest;
      end
      PH_FETCH: begin
        out_valid = 1'b1;
        out_kind  = (kind_q == RQ_WRITE) ? MO_FETCH_INV : MO_FETCH;
        out_dest  = owner_q;
      end
      PH_REPLY: begin
        out_valid = 1'b1;
        out_kind  = MO_REPLY;
        out_data  = mem_rdata;
      end
      default: ;
    endcase
  end
  assign out_addr = addr_q;

  // ---------------- assertions ----------------
  logic          inv_seen_q;
  logic [PW-1:0] last_inv_q;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      inv_seen_q <= 1'b0;
      last_inv_q <= '0;
    end else if (acc_fire) begin
      inv_seen_q <= 1'b0;
    end else if (inv_fire) begin
      inv_seen_q <= 1'b1;
      last_inv_q <= out_dest;
    end
  end

  // R4
  inv_ascend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_fire && inv_seen_q) |-> (out_dest > last_inv_q));

  // R9
  msg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> out_valid && $stable(out_kind) && $stable(out_dest)
                                  && $stable(out_addr) && $stable(out_data));

  // R10
  one_at_a_time_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_fire && req_k != RQ_WBACK) |=> !req_ready);

  // R5
  excl_single_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dir_we && dir_wdata[EW-1 -: 2] == DS_EXC) |-> ($countones(dir_wdata[NPROC-1:0]) == 1));

  // R8
  unc_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dir_we && dir_wdata[EW-1 -: 2] == DS_UNC) |-> (dir_wdata[NPROC-1:0] == '0));

  // R6
  fetch_then_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_fire && (out_kind == MO_FETCH || out_kind == MO_FETCH_INV)) |=> !out_valid && !req_ready);

endmodule

// File: tb/dir_home_ctrl_test.sv
module dir_home_ctrl_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic        req_ready;
  logic [1:0]  req_kind;
  logic [1:0]  req_proc;
  logic [3:0]  req_addr;
  logic [31:0] req_data;
  logic        fbk_valid;
  logic [31:0] fbk_data;
  logic        out_valid;
  logic        out_ready;
  logic [2:0]  out_kind;
  logic [1:0]  out_dest;
  logic [3:0]  out_addr;
  logic [31:0] out_data;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  dir_home_ctrl uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_kind(req_kind), .req_proc(req_proc), .req_addr(req_addr), .req_data(req_data),
    .fbk_valid(fbk_valid), .fbk_data(fbk_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_kind(out_kind), .out_dest(out_dest), .out_addr(out_addr), .out_data(out_data)
  );

  typedef struct packed {
    logic [1:0]  kind;   // 0 read, 1 write, 2 write-back
    logic [1:0]  proc;
    logic [3:0]  addr;
    logic [31:0] data;   // write-back data or fetch-response data
    logic [2:0]  fkind;  // expected fetch kind (0 none, 2 fetch, 3 fetch-inv)
    logic [1:0]  fdest;
    logic [3:0]  inv;    // expected set of invalidated processors
    logic        rep;    // reply expected
    logic [31:0] rdata;  // expected reply data
  } vec_t;

  localparam int NV = 14;
  localparam vec_t TBL [NV] = '{
    '{2'd0, 2'd1, 4'd3, 32'h0,         3'd0, 2'd0, 4'b0000, 1'b1, 32'h0},         // R2
    '{2'd0, 2'd2, 4'd3, 32'h0,         3'd0, 2'd0, 4'b0000, 1'b1, 32'h0},         // R3
    '{2'd0, 2'd0, 4'd3, 32'h0,         3'd0, 2'd0, 4'b0000, 1'b1, 32'h0},         // R3
    '{2'd1, 2'd2, 4'd3, 32'h0,         3'd0, 2'd0, 4'b0011, 1'b1, 32'h0},         // R4 skip requester
    '{2'd0, 2'd3, 4'd3, 32'hAAAA0003,  3'd2, 2'd2, 4'b0000, 1'b1, 32'hAAAA0003},  // R6
    '{2'd1, 2'd0, 4'd3, 32'h0,         3'd0, 2'd0, 4'b1100, 1'b1, 32'hAAAA0003},  // R4 owner kept as sharer
    '{2'd1, 2'd1, 4'd3, 32'hBBBB0003,  3'd3, 2'd0, 4'b0000, 1'b1, 32'hBBBB0003},  // R7
    '{2'd2, 2'd1, 4'd3, 32'hCCCC0003,  3'd0, 2'd0, 4'b0000, 1'b0, 32'h0},         // R8 owner write-back
    '{2'd0, 2'd2, 4'd3, 32'h0,         3'd0, 2'd0, 4'b0000, 1'b1, 32'hCCCC0003},  // R8 now Uncached, R2
    '{2'd2, 2'd2, 4'd3, 32'hDEAD0003,  3'd0, 2'd0, 4'b0000, 1'b0, 32'h0},         // R8 stale write-back
    '{2'd1, 2'd2, 4'd3, 32'h0,         3'd0, 2'd0, 4'b0000, 1'b1, 32'hCCCC0003},  // R4 sole sharer, R8 ignored
    '{2'd1, 2'd3, 4'd7, 32'h0,         3'd0, 2'd0, 4'b0000, 1'b1, 32'h0},         // R5
    '{2'd2, 2'd0, 4'd7, 32'h11110007,  3'd0, 2'd0, 4'b0000, 1'b0, 32'h0},         // R8 non-owner
    '{2'd0, 2'd1, 4'd7, 32'h77770007,  3'd2, 2'd3, 4'b0000, 1'b1, 32'h77770007}   // R6, R5 owner
  };

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic send_req(input vec_t v);
    @(negedge clk);
    req_valid = 1'b1;
    req_kind  = v.kind;
    req_proc  = v.proc;
    req_addr  = v.addr;
    req_data  = v.data;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic run_vec(input vec_t v, input int idx);
    logic [3:0]  inv_got = '0;
    int          last_inv = -1;
    bit          order_ok = 1'b1;
    logic [2:0]  fk = '0;
    logic [1:0]  fd = '0;
    bit          got_rep = 1'b0;
    logic [31:0] rep_d = '0;
    logic [1:0]  rep_dest = '0;
    bit          fb_pending = 1'b0;
    bit          stalled = 1'b0;
    bit          hold_ok = 1'b1;
    logic [2:0]  st_kind = '0;
    logic [1:0]  st_dest = '0;
    logic [31:0] st_data = '0;
    bit          any_out = 1'b0;
    send_req(v);
    if (!v.rep) begin
      out_ready = 1'b1;
      for (int c = 0; c < 6; c++) begin
        @(negedge clk);
        if (out_valid) any_out = 1'b1;
      end
      // R8
      check(!any_out, $sformatf("R8 vec %0d write-back emits no message", idx), 32'(any_out), 32'h0);
      check(req_ready, $sformatf("R8 vec %0d ready after write-back", idx), 32'(req_ready), 32'h1);
      return;
    end
    for (int c = 0; c < 80 && !got_rep; c++) begin
      if (c != 0) @(negedge clk);
      fbk_valid = 1'b0;
      if (fb_pending) begin
        fbk_valid  = 1'b1;
        fbk_data   = v.data;
        fb_pending = 1'b0;
      end
      if (stalled) begin
        if (!(out_valid && out_kind == st_kind && out_dest == st_dest && out_data == st_data))
          hold_ok = 1'b0;
      end
      out_ready = (c % 3 != 1);
      #1;
      stalled = out_valid && !out_ready;
      st_kind = out_kind; st_dest = out_dest; st_data = out_data;
      if (out_valid && out_ready) begin
        case (out_kind)
          3'd1: begin
            if (int'(out_dest) <= last_inv) order_ok = 1'b0;
            last_inv = int'(out_dest);
            inv_got[out_dest] = 1'b1;
          end
          3'd2, 3'd3: begin
            fk = out_kind; fd = out_dest; fb_pending = 1'b1;
          end
          3'd4: begin
            got_rep = 1'b1; rep_d = out_data; rep_dest = out_dest;
          end
          default: ;
        endcase
      end
    end
    @(negedge clk);
    fbk_valid = 1'b0;
    out_ready = 1'b1;
    // R4
    check(inv_got == v.inv, $sformatf("R4 vec %0d invalidate set", idx), 32'(inv_got), 32'(v.inv));
    check(order_ok, $sformatf("R4 vec %0d invalidate order", idx), 32'(order_ok), 32'h1);
    // R6 R7
    check(fk == v.fkind && (fk == 3'd0 || fd == v.fdest),
          $sformatf("R6/R7 vec %0d fetch kind,dest", idx), {24'h0, 1'b0, fk, 2'b0, fd}, {24'h0, 1'b0, v.fkind, 2'b0, v.fdest});
    // R2 R3 R5
    check(got_rep && rep_dest == v.proc, $sformatf("R2/R3/R5 vec %0d reply dest", idx), 32'(rep_dest), 32'(v.proc));
    check(rep_d == v.rdata, $sformatf("R2/R3/R5 vec %0d reply data", idx), rep_d, v.rdata);
    // R9
    check(hold_ok, $sformatf("R9 vec %0d stalled message held", idx), 32'(hold_ok), 32'h1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    vec_t d;
    bit   refused;
    rst_n = 1'b0; req_valid = 1'b0; req_kind = '0; req_proc = '0; req_addr = '0;
    req_data = '0; fbk_valid = 1'b0; fbk_data = '0; out_ready = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    check(req_ready == 1'b1, "R1 req_ready after reset", 32'(req_ready), 32'h1);
    check(out_valid == 1'b0, "R1 out_valid after reset", 32'(out_valid), 32'h0);

    for (int i = 0; i < NV; i++) run_vec(TBL[i], i);

    // R10: fetch outstanding, a request for the same block is refused
    d = '{2'd1, 2'd2, 4'd9, 32'h0, 3'd0, 2'd0, 4'b0000, 1'b1, 32'h0};   // R5 write miss Uncached
    run_vec(d, 100);
    d = '{2'd0, 2'd0, 4'd9, 32'h0, 3'd0, 2'd0, 4'b0000, 1'b1, 32'h0};
    send_req(d);
    out_ready = 1'b1;
    for (int c = 0; c < 10 && !(out_valid && out_kind == 3'd2); c++) @(negedge clk);
    check(out_valid && out_kind == 3'd2 && out_dest == 2'd2, "R6 fetch to owner",
          {29'h0, out_kind}, 32'h2);
    @(negedge clk);
    req_valid = 1'b1; req_kind = 2'd0; req_proc = 2'd3; req_addr = 4'd9;
    refused = 1'b1;
    for (int c = 0; c < 5; c++) begin
      @(negedge clk);
      if (req_ready || out_valid) refused = 1'b0;
    end
    req_valid = 1'b0;
    // R10
    check(refused, "R10 request refused while fetch outstanding", 32'(refused), 32'h1);
    fbk_valid = 1'b1; fbk_data = 32'h99990009;
    @(negedge clk);
    fbk_valid = 1'b0;
    check(out_valid && out_kind == 3'd4 && out_dest == 2'd0 && out_data == 32'h99990009,
          "R6 reply after fetch response", out_data, 32'h99990009);
    check(!req_ready, "R10 ready low until reply handshake", 32'(req_ready), 32'h0);
    @(negedge clk);
    check(req_ready, "R10 ready after reply handshake", 32'(req_ready), 32'h1);
    d = '{2'd0, 2'd3, 4'd9, 32'h0, 3'd0, 2'd0, 4'b0000, 1'b1, 32'h99990009}; // R6 block now Shared, memory written
    run_vec(d, 101);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule